// File: doc/BRIEF.md
# Dual Page Buffer Load Sequencer

This block sits behind a simple host write bus and turns a multi-cycle "load page buffer" command into writes into one of two 256-byte on-chip page buffers. The host first writes the load opcode. It then writes the transfer count as two halves, and finally writes that many offset/data pairs. Each pair lands in the buffer that was active when the command began. A second opcode, accepted only between commands, swaps which of the two buffers is active. The programming of a flash array from a buffer is done elsewhere. Such a later step must use an array destination whose in-page offset matches the buffer offset.

The bus runs either byte-wide or word-wide. In word mode a buffer holds 128 words, with the low byte at the even byte offset. The count field is biased by one. Its high half must be zero, so a transfer never runs past one 256-byte page. A nonzero high half is reported on a one-cycle error pulse and the command is dropped. A one-cycle done pulse marks the storing of the last item. A combinational read port exposes every buffer byte.

Top module: `pbuf_load_seq`

## Requirements
- R1: After reset, `active_buf` is 0 and `done` and `cnt_err` are 0.
- R2: Between commands, a write with `wdata[7:0]` = 8'h72 toggles `active_buf` on the next clock. Any other value besides 8'hE8 (the load opcode) is ignored and leaves `active_buf` unchanged.
- R3: A load opcode (8'hE8 on `wdata[7:0]`) is followed by two count writes and then exactly low_half+1 data writes. `done` is high for exactly the one cycle after the clock edge that stores the last item, and it is low after every earlier write.
- R4: The count halves come from `wdata[7:0]`. If `addr[0]` of the first count write is 0, that write is the low half; if it is 1, that write is the high half. The second count write always supplies the other half, whatever its address.
- R5: In word mode (`byte_mode`=0), `wdata[15:8]` has no effect on the opcode or on either count half.
- R6: If the high count half is nonzero, `cnt_err` is high for the one cycle after the second count write. The sequencer then returns to idle, and writes that follow do not alter any buffer byte.
- R7: In byte mode, each data write stores `wdata[7:0]` at byte offset `addr[7:0]` of the buffer that was active when the load opcode arrived.
- R8: In word mode, each data write stores `wdata[7:0]` at byte offset 2*`addr[6:0]` and `wdata[15:8]` at byte offset 2*`addr[6:0]`+1.
- R9: While a load is in progress, data values equal to an opcode are stored as plain data, and `active_buf` does not change.
- R10: `rd_data` shows byte `rd_addr` of buffer `rd_sel` in the same cycle, and it reflects a stored item from the cycle after its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_mode | input | 1 | 1 = byte-wide bus, 0 = word-wide bus |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| addr | input | ADDR_W | Host address: count half select or page offset |
| wdata | input | 16 | Host write data |
| rd_sel | input | 1 | Buffer chosen for the read port |
| rd_addr | input | 8 | Byte offset for the read port |
| active_buf | output | 1 | Index of the active buffer |
| rd_data | output | 8 | Byte read from the buffers |
| done | output | 1 | One-cycle pulse after the last item is stored |
| cnt_err | output | 1 | One-cycle pulse on an illegal count |

## Verification
The assertions assume that the host holds `byte_mode` steady for the whole of a command. They also assume that between writes the read port inputs change only while `wr_en` is low, so a stable read address with no write must show stable data. The bench drives every input at the falling clock edge. It changes `byte_mode` only between commands and moves the read port only after the write strobe has dropped. Its data offsets come from an odd stride, so no offset repeats within one load, and an expected byte image is kept only for offsets that were actually written.

// File: rtl/pbuf_load_seq.sv
module pbuf_load_seq #(
  parameter int ADDR_W = 8,
  parameter logic [7:0] LOAD_OP = 8'hE8,
  parameter logic [7:0] SWAP_OP = 8'h72
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              rd_sel,
  input  logic [7:0]        rd_addr,
  output logic              active_buf,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic              cnt_err
);
  localparam int PAGE_BYTES = 256;
  localparam int OFS_W = $clog2(PAGE_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_CNT1, S_CNT2, S_DATA} st_t;

  st_t            st;
  logic           first_hi;
  logic           load_buf;
  logic [7:0]     half1;
  logic [OFS_W:0] remain;
  logic [7:0]     mem [2*PAGE_BYTES];

  wire [7:0]       op     = wdata[7:0];
  wire [7:0]       cnt_lo = first_hi ? wdata[7:0] : half1;
  wire [7:0]       cnt_hi = first_hi ? half1 : wdata[7:0];
  wire [OFS_W-1:0] ofs    = byte_mode ? addr[OFS_W-1:0] : {addr[OFS_W-2:0], 1'b0};
  wire             data_wr = wr_en && st == S_DATA;

  always_ff @(posedge clk) begin
    if (data_wr) begin
      mem[{load_buf, ofs}] <= wdata[7:0];
      if (!byte_mode) mem[{load_buf, ofs[OFS_W-1:1], 1'b1}] <= wdata[15:8];
    end
  end

  assign rd_data = mem[{rd_sel, rd_addr}];

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      active_buf <= 1'b0;
      load_buf   <= 1'b0;
      first_hi   <= 1'b0;
      half1      <= '0;
      remain     <= '0;
      done       <= 1'b0;
      cnt_err    <= 1'b0;
    end else begin
      done    <= 1'b0;
      cnt_err <= 1'b0;
      if (wr_en) begin
        case (st)
          S_IDLE: begin
            if (op == LOAD_OP) begin
              st       <= S_CNT1;
              load_buf <= active_buf;
            end else if (op == SWAP_OP) begin
              active_buf <= ~active_buf;
            end
          end
          S_CNT1: begin
            first_hi <= addr[0];
            half1    <= wdata[7:0];
            st       <= S_CNT2;
          end
          S_CNT2: begin
            if (cnt_hi != 8'h00) begin
              cnt_err <= 1'b1;
              st      <= S_IDLE;
            end else begin
              remain <= {1'b0, cnt_lo} + 1'b1;
              st     <= S_DATA;
            end
          end
          default: begin
            remain <= remain - 1'b1;
            if (remain == 1) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end
          end
        endcase
      end
    end
  end
endmodule

module pbuf_load_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       active_buf,
  input logic       done,
  input logic       cnt_err,
  input logic       rd_sel,
  input logic [7:0] rd_addr,
  input logic [7:0] rd_data
);
  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R6
  err_single_chk: assert property (@(posedge clk) disable iff (rst) cnt_err |=> !cnt_err);
  // R6
  err_not_done_chk: assert property (@(posedge clk) disable iff (rst) cnt_err |-> !done);
  // R2
  swap_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(active_buf) |-> $past(wr_en));
  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && $stable(rd_sel) && $stable(rd_addr)) |-> $stable(rd_data));
endmodule

bind pbuf_load_seq pbuf_load_seq_chk chk_i (.*);

// File: tb/tb_pbuf_load_seq.sv
`timescale 1ns/1ps
module tb_pbuf_load_seq;
  logic clk = 0, rst = 1, byte_mode = 1, wr_en = 0, rd_sel = 0;
  logic [7:0] addr = 0, rd_addr = 0;
  logic [15:0] wdata = 0;
  logic active_buf, done, cnt_err;
  logic [7:0] rd_data;
  int errors = 0, checks = 0;
  bit finished = 0;
  logic [7:0] expm [512];
  bit vld [512];
  logic act = 0;

  always #2 clk = ~clk;

  pbuf_load_seq dut (.*);

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; #0.5;
  endtask

  task automatic verify_all(input string req);
    for (int i = 0; i < 512; i++) if (vld[i]) begin
      rd_sel = i[8]; rd_addr = i[7:0]; #0.1;
      chk(rd_data == expm[i], req, rd_data, expm[i]);
    end
  endtask

  task automatic swap();
    wr(8'h00, 16'h0072); act = ~act;
    chk(active_buf == act, "R2 swap", active_buf, act);
  endtask

  task automatic load_byte(input int n, input bit hi_first, input int seed);
    byte_mode = 1;
    wr(8'h00, 16'h00E8);
    if (hi_first) begin wr(8'h01, 16'h0000); wr(8'h01, 16'(n - 1)); end
    else begin wr(8'h00, 16'(n - 1)); wr(8'h00, 16'h0000); end
    for (int k = 0; k < n; k++) begin
      int ofs; int d;
      ofs = (seed + k * 37) & 255;
      d = (k == 0) ? 8'h72 : ((k * 13 + seed) & 255);
      wr(8'(ofs), 16'(d));
      expm[{act, 8'(ofs)}] = 8'(d); vld[{act, 8'(ofs)}] = 1;
      chk(done == (k == n - 1), "R3 done timing (byte)", done, k == n - 1);
    end
    chk(active_buf == act, "R9 opcode-valued data ignored", active_buf, act);
    verify_all("R7 byte store");
  endtask

  task automatic load_word(input int n, input bit hi_first, input int seed);
    byte_mode = 0;
    wr(8'h00, 16'h5AE8);
    if (hi_first) begin wr(8'h01, 16'hFF00); wr(8'h01, 16'hC300 | 16'(n - 1)); end
    else begin wr(8'h00, 16'h3C00 | 16'(n - 1)); wr(8'h00, 16'hA500); end
    for (int k = 0; k < n; k++) begin
      int ofs; logic [7:0] lo, hi;
      ofs = (seed + k * 37) & 127;
      lo = 8'(k * 11 + 1); hi = 8'(k * 5 + seed);
      wr(8'(ofs), {hi, lo});
      expm[{act, 7'(ofs), 1'b0}] = lo; vld[{act, 7'(ofs), 1'b0}] = 1;
      expm[{act, 7'(ofs), 1'b1}] = hi; vld[{act, 7'(ofs), 1'b1}] = 1;
      chk(done == (k == n - 1), "R5 R3 done timing (word)", done, k == n - 1);
    end
    byte_mode = 1;
    verify_all("R8 word store");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; #0.5;
    chk(active_buf == 0, "R1 reset active_buf", active_buf, 0);
    chk(done == 0, "R1 reset done", done, 0);
    chk(cnt_err == 0, "R1 reset cnt_err", cnt_err, 0);

    swap();
    wr(8'h00, 16'h0055);
    chk(active_buf == act, "R2 other opcode ignored", active_buf, act);
    swap();

    load_byte(256, 0, 3);
    swap();
    load_byte(5, 1, 17);
    for (int n = 1; n <= 12; n++) begin
      swap();
      load_byte(n, n[0], n * 29);
    end

    // R6: illegal high half, then a stray write must not land in a buffer
    wr(8'h00, 16'h00E8); wr(8'h00, 16'h0003); wr(8'h00, 16'h0001);
    chk(cnt_err == 1, "R6 cnt_err pulse", cnt_err, 1);
    wr(8'h10, 16'h0011);
    chk(cnt_err == 0, "R6 cnt_err single", cnt_err, 0);
    chk(done == 0, "R6 no done", done, 0);
    wr(8'h00, 16'h00E8); wr(8'h01, 16'h0002); wr(8'h00, 16'h0000);
    chk(cnt_err == 1, "R4 high-first error", cnt_err, 1);
    verify_all("R6 buffers unchanged");

    swap();
    load_word(128, 0, 9);
    for (int n = 1; n <= 8; n++) begin
      swap();
      load_word(n, ~n[0], n * 7);
    end
    byte_mode = 0;
    wr(8'h00, 16'h00E8); wr(8'h01, 16'h0004); wr(8'h01, 16'hEE00);
    chk(cnt_err == 1, "R5 R6 word error pulse", cnt_err, 1);
    byte_mode = 1;
    verify_all("R6 word error no change");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule